// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the sending side of a clocked synchronous serial port. Software places a byte in a transmit data register and then clears the data-register-empty flag. The transmitter copies the byte into a shift register and sets the empty flag again at once, so the next byte can be written while the current one is still on the wire. It then sends the bits least significant first on a data pin. Each bit is launched on a falling serial clock edge so that a receiver can capture it on the following rising edge.

The serial clock is either generated inside the block from the system clock, with a programmable half-period, or taken from an external clock input. The empty flag is sampled when the most significant bit is launched. If a new byte is already waiting, it is loaded and its frame follows with no gap. If no byte is waiting, the transmit-end flag is raised, the last bit is completed, the data pin keeps that level and the serial clock rests high.

Two interrupt request levels are provided: transmit-data-empty and transmit-end, each formed from its flag and its enable. Software accesses the block through a small write-only register port: data, control, status clear and divider.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset the empty flag and the end flag read 1, the serial clock output and the data output are high, and both interrupt requests are low.
- R2: Writing address 2 with bit 0 equal to 0 clears the empty flag. When the transmitter is enabled and idle, the byte held at address 0 is loaded into the shift register one cycle later and the empty flag returns to 1. The empty interrupt request equals the empty flag AND the control bit 1 enable.
- R3: A frame carries the loaded byte least significant bit first. Each bit changes only on a falling serial clock edge and is stable at the next rising edge.
- R4: Each frame has exactly eight serial clock pulses. Between frames the serial clock output stays high.
- R5: In internal clock mode each serial clock half-period lasts (divider + 1) system clocks. The divider is written at address 3.
- R6: If the empty flag is 0 when the most significant bit is launched, the waiting byte is loaded and its first bit follows with the same pulse spacing, leaving no gap between frames.
- R7: If the empty flag is 1 when the most significant bit is launched, the end flag is set and the most significant bit stays on the data output after the frame. The end interrupt request equals the end flag AND the control bit 2 enable.
- R8: A write to the data register (address 0) clears the end flag.
- R9: With control bit 3 set (external clock mode), each bit is launched on a falling edge of the external clock input, and the serial clock output stays high.
- R10: While control bit 0 (transmit enable) is 0, no frame starts, the serial clock stays high, the data output does not change, and the empty flag reads 1 even after a clear request.
- R11: A write to address 2 with bit 0 equal to 1 has no effect: the empty flag stays 1 and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 data, 1 control, 2 status clear, 3 divider |
| wr_data | input | DATA_W | Write data |
| sclk_in | input | 1 | External serial clock, used in external clock mode |
| sclk_o | output | 1 | Generated serial clock, high when idle or in external mode |
| txd_o | output | 1 | Serial data output |
| tdre_o | output | 1 | Data-register-empty flag |
| tend_o | output | 1 | Transmit-end flag |
| txi_o | output | 1 | Transmit-data-empty interrupt request |
| tei_o | output | 1 | Transmit-end interrupt request |

## Verification
Register effects appear one system clock after the write edge. A clear request is followed, one further cycle later, by the reload that sets the empty flag and raises the empty interrupt. The bench samples those flags on the falling clock edges at exactly those points. Serial data is due at each rising serial clock edge, either (divider + 1) cycles after the launching fall or, in external mode, after a three-cycle synchronizer delay behind the external fall. The scoreboard monitor therefore captures the data pin only on detected rising edges of the active serial clock and compares each assembled byte with the queued one. Pulse spacing is checked from recorded edge times, and the end-of-frame flag and pin levels are checked after the last pulse has settled.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef logic [1:0] addr_t;

    localparam addr_t ADDR_DATA = 2'd0;
    localparam addr_t ADDR_CTRL = 2'd1;
    localparam addr_t ADDR_STAT = 2'd2;
    localparam addr_t ADDR_DIV  = 2'd3;

    // bit 0 enable, bit 1 empty irq enable, bit 2 end irq enable, bit 3 external clock
    typedef struct packed {
        logic ext;
        logic teie;
        logic tie;
        logic te;
    } ctrl_t;
endpackage

// File: rtl/sst_regs.sv
module sst_regs
    import sst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  addr_t             wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] tdr,
    output logic [DIV_W-1:0]  div,
    output logic              data_wr,
    output logic              clr_req
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] tdr;
        logic [DIV_W-1:0]  div;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_DATA: r_d.tdr  = wr_data;
                ADDR_CTRL: r_d.ctrl = ctrl_t'(wr_data[3:0]);
                ADDR_DIV:  r_d.div  = wr_data[DIV_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl    = r_q.ctrl;
    assign tdr     = r_q.tdr;
    assign div     = r_q.div;
    assign data_wr = wr_en && (wr_addr == ADDR_DATA);
    assign clr_req = wr_en && (wr_addr == ADDR_STAT) && !wr_data[0];
endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    input  logic             sclk_in,
    output logic             fall_ev,
    output logic             rise_ev,
    output logic             sclk_int
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
        logic [2:0]       sync;
    } cg_t;

    cg_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.sync = {c_q.sync[1:0], sclk_in};
        fall_ev  = 1'b0;
        rise_ev  = 1'b0;
        if (!active || ext_mode) begin
            c_d.cnt = '0;
            c_d.ph  = 1'b1;
        end else if (c_q.cnt == div) begin
            c_d.cnt = '0;
            c_d.ph  = !c_q.ph;
            fall_ev = c_q.ph;
            rise_ev = !c_q.ph;
        end else begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
        if (ext_mode) begin
            fall_ev = c_q.sync[2] && !c_q.sync[1];
            rise_ev = !c_q.sync[2] && c_q.sync[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{cnt: '0, ph: 1'b1, sync: 3'b111};
        else        c_q <= c_d;
    end

    assign sclk_int = c_q.ph;
endmodule

// File: rtl/sst_txeng.sv
module sst_txeng #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te,
    input  logic [DATA_W-1:0] tdr,
    input  logic              data_wr,
    input  logic              clr_req,
    input  logic              fall_ev,
    input  logic              rise_ev,
    output logic              active,
    output logic              txd,
    output logic              tdre,
    output logic              tend
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              active;
        logic              hi;
        logic              chain;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              txd;
        logic              tdre;
        logic              tend;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (data_wr) e_d.tend = 1'b0;
        if (clr_req) e_d.tdre = 1'b0;
        if (!te) begin
            e_d.active = 1'b0;
            e_d.hi     = 1'b1;
            e_d.chain  = 1'b0;
            e_d.cnt    = '0;
            e_d.tdre   = 1'b1;
            e_d.tend   = 1'b1;
        end else if (!e_q.active) begin
            if (!e_q.tdre) begin
                e_d.shreg  = tdr;
                e_d.tdre   = 1'b1;
                e_d.active = 1'b1;
                e_d.hi     = 1'b1;
                e_d.chain  = 1'b0;
                e_d.cnt    = '0;
            end
        end else if (e_q.hi && fall_ev) begin
            e_d.hi    = 1'b0;
            e_d.txd   = e_q.shreg[0];
            e_d.shreg = e_q.shreg >> 1;
            if (e_q.cnt == LAST) begin
                if (!e_q.tdre) begin
                    e_d.shreg = tdr;
                    e_d.tdre  = 1'b1;
                    e_d.chain = 1'b1;
                end else begin
                    e_d.tend  = 1'b1;
                end
            end
        end else if (!e_q.hi && rise_ev) begin
            e_d.hi = 1'b1;
            if (e_q.cnt == LAST) begin
                e_d.cnt = '0;
                if (e_q.chain) e_d.chain  = 1'b0;
                else           e_d.active = 1'b0;
            end else begin
                e_d.cnt = e_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{active: 1'b0, hi: 1'b1, chain: 1'b0, cnt: '0,
                             shreg: '0, txd: 1'b1, tdre: 1'b1, tend: 1'b1};
        else        e_q <= e_d;
    end

    assign active = e_q.active;
    assign txd    = e_q.txd;
    assign tdre   = e_q.tdre;
    assign tend   = e_q.tend;
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sclk_in,
    output logic              sclk_o,
    output logic              txd_o,
    output logic              tdre_o,
    output logic              tend_o,
    output logic              txi_o,
    output logic              tei_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] tdr;
    logic [DIV_W-1:0]  div;
    logic              data_wr, clr_req;
    logic              fall_ev, rise_ev, sclk_int, active;
    logic              ctrl_te, ctrl_ext;

    sst_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .tdr(tdr), .div(div),
        .data_wr(data_wr), .clr_req(clr_req)
    );

    assign ctrl_te  = ctrl.te;
    assign ctrl_ext = ctrl.ext;

    sst_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .ext_mode(ctrl_ext), .active(active),
        .div(div), .sclk_in(sclk_in), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .sclk_int(sclk_int)
    );

    sst_txeng #(.DATA_W(DATA_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .te(ctrl_te), .tdr(tdr), .data_wr(data_wr),
        .clr_req(clr_req), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .active(active), .txd(txd_o), .tdre(tdre_o), .tend(tend_o)
    );

    assign sclk_o = ctrl_ext | sclk_int | ~active;
    assign txi_o  = tdre_o & ctrl.tie;
    assign tei_o  = tend_o & ctrl.teie;
endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic clr_req,
    input logic data_wr,
    input logic tdre_o,
    input logic tend_o,
    input logic sclk_o,
    input logic txd_o,
    input logic ctrl_te,
    input logic ctrl_ext
);
    // R10
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_te |=> tdre_o)
        else $error("empty flag not held while disabled");

    // R2 R11
    tdre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tdre_o) |-> $past(clr_req))
        else $error("empty flag fell without a clear request");

    // R8
    tend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tend_o) |-> $past(data_wr))
        else $error("end flag fell without a data write");

    // R7
    tend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend_o) && ctrl_te && $past(ctrl_te) |-> $past(tdre_o))
        else $error("end flag set while a byte was waiting");

    // R3
    txd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_te && $past(ctrl_te) && !ctrl_ext && !$past(ctrl_ext) && !$stable(txd_o)
        |-> $fell(sclk_o))
        else $error("data changed away from a falling serial clock");
endmodule

bind sync_ser_tx sync_ser_tx_chk chk_i (.*);

// File: tb/sync_ser_tx_tb_top.sv
module sync_ser_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       sclk_in;
    logic       sclk_o, txd_o, tdre_o, tend_o, txi_o, tei_o;

    always #4 clk = ~clk;

    sync_ser_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sclk_in(sclk_in), .sclk_o(sclk_o), .txd_o(txd_o),
        .tdre_o(tdre_o), .tend_o(tend_o), .txi_o(txi_o), .tei_o(tei_o)
    );

    int         checks = 0;
    int         failures = 0;
    int         cyc = 0;
    logic [7:0] exp_q[$];
    int         rise_t[$];
    logic       ext_tb = 1'b0;
    int         sclk_falls = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor: captures txd on rising edges of the active serial clock
    logic       line_prev = 1'b1;
    logic       sclk_prev = 1'b1;
    logic [7:0] sh = '0;
    int         nbits = 0;
    always @(negedge clk) begin
        logic line;
        line = ext_tb ? sclk_in : sclk_o;
        if (ext_tb && sclk_prev && !sclk_o) sclk_falls++;
        sclk_prev = sclk_o;
        if (rst_n && !line_prev && line) begin
            rise_t.push_back(cyc);
            sh = {txd_o, sh[7:1]};
            nbits++;
            if (nbits == 8) begin
                nbits = 0;
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected frame", sh, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(sh == e, "R3 frame byte", sh, e);
                end
            end
        end
        line_prev = line;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        while (!tdre_o) @(negedge clk);
        exp_q.push_back(b);
        wr(2'd0, b);
        wr(2'd2, 8'h00);
    endtask

    task automatic wait_rises(input int n);
        while (rise_t.size() < n) @(negedge clk);
    endtask

    task automatic check_spacing(input int n, input int period, input string req);
        int bad = 0;
        chk(rise_t.size() == n, {req, " pulse count"}, rise_t.size(), n);
        for (int i = 1; i < rise_t.size(); i++)
            if (rise_t[i] - rise_t[i-1] != period) bad++;
        chk(bad == 0, {req, " pulse spacing"}, bad, 0);
    endtask

    task automatic ext_pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 sclk_in = 1'b0;
            repeat (half) @(posedge clk);
            #1 sclk_in = 1'b1;
            repeat (half) @(posedge clk);
        end
    endtask

    bit done = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sclk_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tdre_o == 1'b1, "R1 empty flag", tdre_o, 1);
        chk(tend_o == 1'b1, "R1 end flag", tend_o, 1);
        chk(sclk_o == 1'b1 && txd_o == 1'b1, "R1 pins high", {sclk_o, txd_o}, 3);
        chk(txi_o == 1'b0 && tei_o == 1'b0, "R1 irqs low", {txi_o, tei_o}, 0);

        // R10 disabled: clear request ignored
        wr(2'd0, 8'h5A);
        wr(2'd2, 8'h00);
        repeat (40) @(negedge clk);
        chk(tdre_o == 1'b1, "R10 empty flag held", tdre_o, 1);
        chk(rise_t.size() == 0 && sclk_o == 1'b1, "R10 clock idle", rise_t.size(), 0);
        chk(txd_o == 1'b1, "R10 data unchanged", txd_o, 1);

        // enable, half period 4 cycles
        wr(2'd3, 8'd3);
        wr(2'd1, 8'h07);
        exp_q.push_back(8'h35);
        wr(2'd0, 8'h35);
        chk(tend_o == 1'b0, "R8 data write clears end flag", tend_o, 0);
        rise_t.delete();
        wr(2'd2, 8'h00);
        chk(tdre_o == 1'b0 && txi_o == 1'b0, "R2 flag cleared", {tdre_o, txi_o}, 0);
        @(negedge clk);
        chk(tdre_o == 1'b1 && txi_o == 1'b1, "R2 reload sets flag and irq", {tdre_o, txi_o}, 3);
        wait_rises(8);
        repeat (20) @(negedge clk);
        check_spacing(8, 8, "R5");
        chk(tend_o == 1'b1 && tei_o == 1'b1, "R7 end flag and irq", {tend_o, tei_o}, 3);
        chk(txd_o == 1'b0, "R7 data holds MSB", txd_o, 0);
        chk(sclk_o == 1'b1 && rise_t.size() == 8, "R4 eight pulses then high", rise_t.size(), 8);
        wr(2'd1, 8'h03);
        chk(tei_o == 1'b0, "R7 end irq masked", tei_o, 0);

        // R6 back to back, half period 2
        wr(2'd3, 8'd1);
        rise_t.delete();
        send(8'h3C);
        send(8'hC3);
        wait_rises(16);
        repeat (10) @(negedge clk);
        check_spacing(16, 4, "R6");
        chk(tend_o == 1'b1 && txd_o == 1'b1, "R7 end after chain", {tend_o, txd_o}, 3);

        // R6 three frames, half period 1
        wr(2'd3, 8'd0);
        rise_t.delete();
        send(8'h81);
        send(8'h7E);
        send(8'hF0);
        wait_rises(24);
        repeat (10) @(negedge clk);
        check_spacing(24, 2, "R6");

        // R11 write-one to status ignored
        rise_t.delete();
        wr(2'd0, 8'h11);
        wr(2'd2, 8'h01);
        repeat (30) @(negedge clk);
        chk(tdre_o == 1'b1, "R11 empty flag stays", tdre_o, 1);
        chk(rise_t.size() == 0, "R11 no frame", rise_t.size(), 0);
        exp_q.push_back(8'h11);
        wr(2'd2, 8'h00);
        wait_rises(8);
        repeat (10) @(negedge clk);

        // R9 external clock
        wr(2'd1, 8'h09);
        ext_tb = 1'b1;
        rise_t.delete();
        sclk_falls = 0;
        exp_q.push_back(8'h96);
        wr(2'd0, 8'h96);
        wr(2'd2, 8'h00);
        repeat (5) @(negedge clk);
        ext_pulses(8, 10);
        repeat (10) @(negedge clk);
        chk(rise_t.size() == 8, "R9 eight external pulses", rise_t.size(), 8);
        chk(sclk_falls == 0 && sclk_o == 1'b1, "R9 clock output held high", sclk_falls, 0);
        chk(tend_o == 1'b1 && txd_o == 1'b1, "R9 end flag and MSB", {tend_o, txd_o}, 3);

        chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule